// File: doc/BRIEF.md
# Buffered Two-Register PWM Channel Pair

This block is a free-running up-counter with a programmable wrap value. It feeds two linked compare registers that together drive one PWM output. In buffered mode one register controls the waveform and the other stands idle. Software loads a new duty value into the idle register. At the next period boundary the hardware moves output control to that register, so a duty change can never cut a period short or stretch it. A single-register mode and an off mode are also provided. Two control bits give an explicit 0% and 100% duty.

The block raises a sticky overflow flag and one sticky compare flag per register, each cleared by writing one. An interrupt request combines the flags with their enables. A stop input freezes the counter and all timing events without disturbing any state. All configuration goes through one write port: an address, a data word and a write strobe.

Top module: `pwm_pair`

## Requirements
- R1: `count` steps by one per clock from 0 up to the wrap value (address 2), then returns to 0 on the following clock; a period lasts wrap+1 cycles.
- R2: While `stop` is high, `count`, the output and all flags hold their values and no overflow or compare event occurs; counting resumes from the held value once `stop` falls.
- R3: The control register (address 0) selects the mode. Bit 0 set gives buffered mode, whatever bit 1 holds. Bit 1 alone gives single-register mode. Neither bit set holds `pwm_out` low.
- R4: With toggle-on-wrap (control bit 2) set, the output rises on the clock that wraps the counter and falls on the clock after the count equals the controlling compare value C. For C below the wrap value M it is high for C+1 cycles of each period, otherwise for all M+1 cycles.
- R5: On entry to buffered mode the even register (address 3) controls the output. A write to the idle register takes control at the next wrap, and control alternates with each such write. With no such write, control stays where it is.
- R6: In single-register mode only the even register sets the duty; writes to the odd register (address 4) change neither the output nor the odd compare flag.
- R7: With control bit 2 clear, the output never rises, which gives 0% duty.
- R8: With control bits 3 (max duty) and 2 both set in an active mode, `pwm_out` is high at all times. With bit 3 set and bit 2 clear the output is still 0%.
- R9: `ovf_flag` sets on each wrap. `ch_flag[k]` sets when the count matches register k while register k controls the output. Writing 1 to bit 0, 1 or 2 of address 1 clears the overflow, even or odd flag. A set in the same cycle takes priority over the clear.
- R10: `irq` is high when a flag is set and its enable is set: control bit 4 for overflow, bit 5 for the even register and bit 6 for the odd register.
- R11: A write takes effect on the clock edge that samples `wr_en`, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop | input | 1 | Freeze counter and events |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current counter value |
| pwm_out | output | 1 | PWM output |
| ovf_flag | output | 1 | Sticky wrap flag |
| ch_flag | output | 2 | Sticky compare flags, bit 0 even register |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software never sets the wrap value below the current count. Such a write would send the counter on a full-width lap, and the wrap and switching properties would have nothing to pair against. The bench changes the wrap value only after reset or while the count is still below the new limit. It writes the idle register only in mid-period, away from the cycle at the wrap value. Duty is measured over whole periods only after one settling period following any configuration change.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    localparam int NUM_CH    = 2;
    localparam int NUM_FLAGS = NUM_CH + 1;
    localparam int CTRL_BITS = 7;

    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_FLAG = 1;
    localparam int unsigned ADDR_MOD  = 2;
    localparam int unsigned ADDR_CMP0 = 3;

    localparam int FLAG_OVF = 0;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'd0,
        MODE_SINGLE   = 2'd1,
        MODE_BUFFERED = 2'd2
    } pwm_mode_e;

    // bit 0 is buf_en, bit 6 is ch1_ie
    typedef struct packed {
        logic ch1_ie;
        logic ch0_ie;
        logic ovf_ie;
        logic max_duty;
        logic tov;
        logic single_en;
        logic buf_en;
    } pwm_ctrl_t;

    function automatic pwm_mode_e decode_mode(input logic buf_en, input logic single_en);
        if (buf_en)
            return MODE_BUFFERED;
        else if (single_en)
            return MODE_SINGLE;
        else
            return MODE_OFF;
    endfunction

endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CNT_W-1:0]               wr_data,
    input  logic                           evt_ovf,
    input  logic [NUM_CH-1:0]              evt_cmp,
    output pwm_ctrl_t                      ctrl_o,
    output logic [CNT_W-1:0]               mod_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_o,
    output logic [NUM_CH-1:0]              cmp_wr_o,
    output logic [NUM_FLAGS-1:0]           flags_o
);

    logic wr_ctrl, wr_flag, wr_mod;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign wr_flag = wr_en && (wr_addr == ADDR_W'(ADDR_FLAG));
    assign wr_mod  = wr_en && (wr_addr == ADDR_W'(ADDR_MOD));

    assign flag_set = {evt_cmp, evt_ovf};
    assign flag_clr = wr_flag ? wr_data[NUM_FLAGS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
            mod_o  <= '1;
        end else begin
            if (wr_ctrl) ctrl_o <= pwm_ctrl_t'(wr_data[CTRL_BITS-1:0]);
            if (wr_mod)  mod_o  <= wr_data;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
        assign cmp_wr_o[ch] = wr_en && (wr_addr == ADDR_W'(ADDR_CMP0 + ch));

        always_ff @(posedge clk) begin
            if (rst)
                cmp_o[ch] <= '0;
            else if (cmp_wr_o[ch])
                cmp_o[ch] <= wr_data;
        end
    end

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_o[f] <= 1'b0;
            else
                flags_o[f] <= flag_set[f] | (flags_o[f] & ~flag_clr[f]);
        end

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            (flags_o[f] && !flag_clr[f]) |=> flags_o[f]); // R9
    end

    AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        evt_ovf |=> flags_o[FLAG_OVF]); // R9

endmodule

// File: rtl/pwm_pair_counter.sv
module pwm_pair_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop,
    input  logic [CNT_W-1:0] mod_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_ev_o
);

    assign ovf_ev_o = !stop && (count_o == mod_i);

    always_ff @(posedge clk) begin
        if (rst)
            count_o <= '0;
        else if (ovf_ev_o)
            count_o <= '0;
        else if (!stop)
            count_o <= count_o + CNT_W'(1);
    end

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        ovf_ev_o |=> (count_o == '0)); // R1

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        stop |=> $stable(count_o)); // R2

endmodule

// File: rtl/pwm_pair_select.sv
module pwm_pair_select
    import pwm_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pwm_mode_e         mode_i,
    input  logic              ovf_ev_i,
    input  logic [NUM_CH-1:0] cmp_wr_i,
    output logic              sel_o
);

    logic pend_q;
    logic wr_idle;
    logic take;

    assign wr_idle = cmp_wr_i[~sel_o];
    assign take    = ovf_ev_i && (pend_q || wr_idle);

    always_ff @(posedge clk) begin
        if (rst || mode_i != MODE_BUFFERED) begin
            sel_o  <= 1'b0;
            pend_q <= 1'b0;
        end else if (take) begin
            sel_o  <= ~sel_o;
            pend_q <= 1'b0;
        end else if (wr_idle) begin
            pend_q <= 1'b1;
        end
    end

    AST_SWAP_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_BUFFERED && ovf_ev_i && pend_q) |=> (sel_o != $past(sel_o))); // R5

    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_BUFFERED && !ovf_ev_i) |=> $stable(sel_o)); // R5

endmodule

// File: rtl/pwm_pair_wave.sv
module pwm_pair_wave
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop,
    input  pwm_mode_e         mode_i,
    input  logic              tov_i,
    input  logic              max_i,
    input  logic              ovf_ev_i,
    input  logic              sel_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CNT_W-1:0]  act_cmp_i,
    output logic [NUM_CH-1:0] cmp_ev_o,
    output logic              pwm_o
);

    logic match;
    logic out_q;

    assign match = !stop && (mode_i != MODE_OFF) && (count_i == act_cmp_i);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_evt
        assign cmp_ev_o[k] = match && (sel_i == 1'(k));
    end

    // wrap takes precedence over a same-cycle compare
    always_ff @(posedge clk) begin
        if (rst || mode_i == MODE_OFF)
            out_q <= 1'b0;
        else if (ovf_ev_i && tov_i)
            out_q <= 1'b1;
        else if (match)
            out_q <= 1'b0;
    end

    assign pwm_o = (mode_i != MODE_OFF) && ((max_i && tov_i) || out_q);

    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
        (!tov_i && !out_q) |=> !out_q); // R7

    AST_RISE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (ovf_ev_i && tov_i && mode_i != MODE_OFF) |=> out_q); // R4

endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              pwm_out,
    output logic              ovf_flag,
    output logic [1:0]        ch_flag,
    output logic              irq
);

    pwm_ctrl_t                     ctrl;
    pwm_mode_e                     mode;
    logic [CNT_W-1:0]              mod_val;
    logic [NUM_CH-1:0][CNT_W-1:0]  cmp_val;
    logic [NUM_CH-1:0]             cmp_wr;
    logic [NUM_CH-1:0]             cmp_ev;
    logic [NUM_FLAGS-1:0]          flags;
    logic                          ovf_ev;
    logic                          sel;

    assign mode = decode_mode(ctrl.buf_en, ctrl.single_en);

    pwm_pair_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .evt_ovf  (ovf_ev),
        .evt_cmp  (cmp_ev),
        .ctrl_o   (ctrl),
        .mod_o    (mod_val),
        .cmp_o    (cmp_val),
        .cmp_wr_o (cmp_wr),
        .flags_o  (flags)
    );

    pwm_pair_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .stop     (stop),
        .mod_i    (mod_val),
        .count_o  (count),
        .ovf_ev_o (ovf_ev)
    );

    pwm_pair_select u_select (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (mode),
        .ovf_ev_i (ovf_ev),
        .cmp_wr_i (cmp_wr),
        .sel_o    (sel)
    );

    pwm_pair_wave #(.CNT_W(CNT_W)) u_wave (
        .clk       (clk),
        .rst       (rst),
        .stop      (stop),
        .mode_i    (mode),
        .tov_i     (ctrl.tov),
        .max_i     (ctrl.max_duty),
        .ovf_ev_i  (ovf_ev),
        .sel_i     (sel),
        .count_i   (count),
        .act_cmp_i (cmp_val[sel]),
        .cmp_ev_o  (cmp_ev),
        .pwm_o     (pwm_out)
    );

    assign ovf_flag = flags[0];
    assign ch_flag  = flags[2:1];
    assign irq      = (flags[0] && ctrl.ovf_ie) ||
                      (flags[1] && ctrl.ch0_ie) ||
                      (flags[2] && ctrl.ch1_ie);

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ovf_flag || ch_flag != 2'b00)); // R10

    AST_STOP_NO_FLAG_RISE: assert property (@(posedge clk) disable iff (rst)
        stop |=> !$rose(ovf_flag)); // R2

    AST_SINGLE_ODD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SINGLE && !ch_flag[1]) |=> !ch_flag[1]); // R6

endmodule

// File: tb/pwm_pair_test.sv
module pwm_pair_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int AW = 3;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stop = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [CW-1:0] count;
    logic          pwm_out, ovf_flag, irq;
    logic [1:0]    ch_flag;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    pwm_pair #(.CNT_W(CW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .stop(stop), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .pwm_out(pwm_out),
        .ovf_flag(ovf_flag), .ch_flag(ch_flag), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = CW'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_count(input int v);
        while (count != CW'(v)) @(negedge clk);
    endtask

    task automatic period_highs(input int m, output int h);
        wait_count(0);
        h = 0;
        for (int i = 0; i <= m; i++) begin
            h += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    task automatic settled_highs(input int m, output int h);
        int dummy;
        period_highs(m, dummy);
        period_highs(m, h);
    endtask

    initial begin
        int h;
        int c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R1 reset count", int'(count), 1);
        chk("R3 reset output", int'(pwm_out), 0);
        chk("R9 reset flags", int'({ch_flag, ovf_flag}), 0);
        chk("R10 reset irq", int'(irq), 0);

        // R1: count sequence with wrap value 5
        wr(2, 5);
        wait_count(0);
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            chk("R1 count step", int'(count), i % 6);
        end

        // R4 sweep in single mode (ctrl 0x06: single + tov), covers R6 path
        for (int mi = 0; mi < 2; mi++) begin
            int m = (mi == 0) ? 3 : 6;
            wait_count(0);
            wr(2, m);
            wr(0, 'h06);
            for (int c = 0; c <= m + 1; c++) begin
                wr(3, c);
                settled_highs(m, h);
                chk("R4 duty sweep", h, (c < m) ? c + 1 : m + 1);
            end
        end

        // R3 off mode holds output low
        wait_count(0);
        wr(2, 7);
        wr(3, 4);
        wr(0, 'h04);
        settled_highs(7, h);
        chk("R3 off mode low", h, 0);

        // R3/R5 buffered mode with single bit also set (0x07): even register first
        wr(3, 2);
        wr(4, 5);
        wr(0, 'h07);
        settled_highs(7, h);
        chk("R5 even register first", h, 3);
        period_highs(7, h);
        chk("R5 no switch without idle write", h, 3);
        @(negedge clk);
        wr(4, 5);
        period_highs(7, h);
        chk("R5 odd takes over at wrap", h, 6);
        @(negedge clk);
        wr(3, 0);
        period_highs(7, h);
        chk("R5 alternates back to even", h, 1);
        @(negedge clk);
        wr(4, 3);
        period_highs(7, h);
        chk("R5 alternates to odd again", h, 4);
        period_highs(7, h);
        chk("R5 control stays on odd", h, 4);

        // R6 single mode ignores odd register
        wr(0, 'h06);
        wr(3, 2);
        settled_highs(7, h);
        chk("R6 single uses even", h, 3);
        @(negedge clk);
        wr(4, 0);
        settled_highs(7, h);
        chk("R6 odd write ignored", h, 3);

        // R7 zero duty with tov clear
        wr(0, 'h02);
        settled_highs(7, h);
        chk("R7 zero duty", h, 0);

        // R8 max without tov stays 0%
        wr(0, 'h0A);
        settled_highs(7, h);
        chk("R8 max without tov", h, 0);

        // R11 write timing, then R8 full duty
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h0E;
        #(CLK_PERIOD/4);
        chk("R11 not before edge", int'(pwm_out), 0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 applied at edge", int'(pwm_out), 1);
        settled_highs(7, h);
        chk("R8 full duty", h, 8);

        // R9 / R2: flags and stop
        wr(0, 'h06);
        wr(3, 3);
        wr(4, 5);
        @(negedge clk);
        stop = 1'b1;
        wr(1, 'h7);
        chk("R9 flags cleared", int'({ch_flag, ovf_flag}), 0);
        c0 = int'(count);
        repeat (5) @(negedge clk);
        chk("R2 count held", int'(count), c0);
        chk("R2 no events while stopped", int'({ch_flag, ovf_flag}), 0);
        stop = 1'b0;
        @(negedge clk);
        chk("R2 resumes from held value", int'(count), (c0 + 1) % 8);
        wait_count(0);
        chk("R9 overflow flag set", int'(ovf_flag), 1);
        wait_count(4);
        chk("R9 even compare flag", int'(ch_flag[0]), 1);
        wait_count(6);
        chk("R6 odd flag quiet in single mode", int'(ch_flag[1]), 0);
        wait_count(7);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 set beats clear", int'(ovf_flag), 1);
        wr(1, 'h01);
        chk("R9 clear by writing one", int'(ovf_flag), 0);
        chk("R9 other flag untouched", int'(ch_flag[0]), 1);

        // R10 interrupt gating
        @(negedge clk);
        stop = 1'b1;
        wr(1, 'h7);
        wr(0, 'h16);
        chk("R10 no irq without flag", int'(irq), 0);
        stop = 1'b0;
        wait_count(0);
        chk("R10 overflow irq", int'(irq), 1);
        wr(0, 'h06);
        chk("R10 masked irq", int'(irq), 0);
        wr(1, 'h1);
        wait_count(4);
        wr(0, 'h26);
        chk("R10 even compare irq", int'(irq), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule